// File: doc/BRIEF.md
# Four-Wide Register Renamer with Zeroing-Idiom Elimination

This block is the rename stage of an out-of-order core. In one clock it takes a group of up to four micro-ops from the decode queue. Each micro-op carries an opcode class, two architectural source registers and one architectural destination. For every micro-op the block:

- looks up the physical tags of the sources;
- takes a fresh physical tag for the destination from a circular free list;
- reports the tag the destination held before, so that tag can be released when the micro-op retires.

Later micro-ops in a group see the writes of earlier ones in the same group. When several micro-ops write one register, the table keeps the youngest mapping.

Some micro-ops clear a register by combining it with itself. The block recognises these by opcode class and equal source registers. Their destination is mapped to the permanently zero physical tag 0. They take no free-list entry and leave rename already complete, with a no-execute flag. Retiring micro-ops return their old tags to the free list, except tag 0.

Top module: `rnm_rename_top`

## Requirements
- R1: After reset, architectural register i maps to physical tag i+1. The free list hands out tags 17, 18, … 63 in ascending order, in lane order within a group.
- R2: A source or old-destination lookup in lane k returns the new tag of the youngest lane below k that writes that register. Only if no such lane exists does it use the table. After the group, the table holds the youngest lane's tag for each written register.
- R3: A micro-op is a zeroing idiom when its two sources are equal and its class is one of 1 (integer xor), 2 (integer subtract), 3 (vector/scalar xor), 4 (packed subtract) or 5 (packed compare-greater). Such a micro-op is output with out_noexec=1 and destination tag 0.
- R4: Equal sources with class 6 (and-not), 0 (other integer) or 7 (misc) give a normal rename. The output has out_noexec=0, a fresh destination tag, and real source tags.
- R5: A zeroing idiom consumes no free-list tag, and its source tags are reported as 0.
- R6: A group of four zeroing idioms is accepted in one cycle even when fewer than four free tags remain.
- R7: in_ready is 1 exactly when the free list holds at least as many tags as the group's valid non-idiom lanes. When in_valid=1 and in_ready=0, no lane is output valid and neither the map nor the free list changes.
- R8: Each valid lane outputs the destination's previous mapping. Tags presented on valid retire lanes are appended to the free list in retire-lane order. Tag 0 is dropped.
- R9: Every non-idiom valid lane receives a nonzero tag, and these tags are distinct within a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group present from the queue |
| in_ready | output | 1 | Group can be accepted this cycle |
| in_lane_vld | input | 4 | Per-lane micro-op valid |
| in_cls | input | 4x3 | Per-lane opcode class |
| in_src1 | input | 4x4 | Per-lane first source register |
| in_src2 | input | 4x4 | Per-lane second source register |
| in_dst | input | 4x4 | Per-lane destination register |
| out_vld | output | 4 | Per-lane renamed micro-op valid |
| out_noexec | output | 4 | Lane completed at rename, no dispatch |
| out_src1_tag | output | 4x6 | Physical tag of first source |
| out_src2_tag | output | 4x6 | Physical tag of second source |
| out_dst_tag | output | 4x6 | New physical tag of destination |
| out_old_tag | output | 4x6 | Previous tag of destination |
| ret_vld | input | 4 | Per-lane retire valid |
| ret_tag | input | 4x6 | Tag released by retirement |

## Verification
The hardest situation to reach from the ports is a nearly empty free list. Proving that stalls follow the count of non-idiom destinations, and not the number of lanes, needs that state. The bench gets there by issuing eight full groups of ordinary micro-ops until exactly three tags remain. It then shows three things:

- a four-lane ordinary group is refused;
- a four-lane idiom group is accepted;
- after a retire that mixes real tags with tag 0, the refill order and count fit R8. A group needing two tags stalls while a one-tag group proceeds.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
    localparam int LANES     = 4;
    localparam int RET_LANES = 4;
    localparam int ARCH_REGS = 16;
    localparam int PHYS_REGS = 64;
    localparam int AW        = $clog2(ARCH_REGS);
    localparam int TW        = $clog2(PHYS_REGS);
    localparam int CLSW      = 3;

    typedef logic [AW-1:0] areg_t;
    typedef logic [TW-1:0] ptag_t;

    typedef enum logic [CLSW-1:0] {
        CLS_INT    = 3'd0,
        CLS_XOR    = 3'd1,
        CLS_SUB    = 3'd2,
        CLS_FXOR   = 3'd3,
        CLS_VSUB   = 3'd4,
        CLS_VCMPGT = 3'd5,
        CLS_ANDN   = 3'd6,
        CLS_MISC   = 3'd7
    } opcls_t;

    localparam ptag_t ZERO_TAG = '0;

    function automatic logic cls_self_clears(input opcls_t c);
        case (c)
            CLS_XOR, CLS_SUB, CLS_FXOR, CLS_VSUB, CLS_VCMPGT: return 1'b1;
            default:                                          return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/rnm_zero_detect.sv
module rnm_zero_detect
    import rnm_pkg::*;
#(
    parameter int ARW = AW
) (
    input  logic [CLSW-1:0] cls,
    input  logic [ARW-1:0]  src_a,
    input  logic [ARW-1:0]  src_b,
    output logic            is_zero
);
    always_comb begin
        is_zero = (src_a == src_b) && cls_self_clears(opcls_t'(cls));
    end
endmodule

// File: rtl/rnm_map_table.sv
module rnm_map_table
    import rnm_pkg::*;
#(
    parameter int NREG = ARCH_REGS,
    parameter int NWR  = LANES,
    parameter int NRD  = 3 * LANES,
    parameter int ARW  = AW,
    parameter int TGW  = TW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NRD-1:0][ARW-1:0]   rd_idx,
    output logic [NRD-1:0][TGW-1:0]   rd_tag,
    input  logic [NWR-1:0]            wr_en,
    input  logic [NWR-1:0][ARW-1:0]   wr_idx,
    input  logic [NWR-1:0][TGW-1:0]   wr_tag
);
    logic [TGW-1:0] map_q [NREG];

    always_comb begin
        for (int r = 0; r < NRD; r++) rd_tag[r] = map_q[rd_idx[r]];
    end

    // Lanes are walked oldest first, so the youngest writer wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) map_q[i] <= TGW'(i + 1);
        end else begin
            for (int w = 0; w < NWR; w++)
                if (wr_en[w]) map_q[wr_idx[w]] <= wr_tag[w];
        end
    end
endmodule

// File: rtl/rnm_free_list.sv
module rnm_free_list
    import rnm_pkg::*;
#(
    parameter int DEPTH      = PHYS_REGS,
    parameter int NPOP       = LANES,
    parameter int NPUSH      = RET_LANES,
    parameter int FIRST_FREE = ARCH_REGS + 1,
    parameter int TGW        = TW
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPOP-1:0]           pop_req,
    input  logic                      pop_go,
    output logic [NPOP-1:0][TGW-1:0]  pop_tag,
    output logic                      enough,
    input  logic [NPUSH-1:0]          push_vld,
    input  logic [NPUSH-1:0][TGW-1:0] push_tag
);
    localparam int PW     = $clog2(DEPTH);
    localparam int CW     = PW + 1;
    localparam int INIT_N = DEPTH - FIRST_FREE;

    logic [TGW-1:0] ring_q [DEPTH];
    logic [PW-1:0]  head_q, tail_q;
    logic [CW-1:0]  cnt_q;

    logic [CW-1:0]  need, npush;
    logic [NPOP-1:0][PW-1:0]  pop_off;
    logic [NPUSH-1:0][PW-1:0] push_off;
    logic [NPUSH-1:0]         push_ok;

    always_comb begin
        need = '0;
        for (int k = 0; k < NPOP; k++) begin
            pop_off[k] = need[PW-1:0];
            pop_tag[k] = ring_q[head_q + need[PW-1:0]];
            if (pop_req[k]) need = need + 1'b1;
        end
        enough = (need <= cnt_q);
        npush = '0;
        for (int k = 0; k < NPUSH; k++) begin
            push_ok[k]  = push_vld[k] && (push_tag[k] != '0);
            push_off[k] = npush[PW-1:0];
            if (push_ok[k]) npush = npush + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                ring_q[i] <= (i < INIT_N) ? TGW'(FIRST_FREE + i) : '0;
            head_q <= '0;
            tail_q <= PW'(INIT_N);
            cnt_q  <= CW'(INIT_N);
        end else begin
            for (int k = 0; k < NPUSH; k++)
                if (push_ok[k]) ring_q[tail_q + push_off[k]] <= push_tag[k];
            tail_q <= tail_q + npush[PW-1:0];
            if (pop_go) head_q <= head_q + need[PW-1:0];
            cnt_q <= cnt_q - (pop_go ? need : '0) + npush;
        end
    end

    logic unused_off;
    always_comb unused_off = ^pop_off;
endmodule

// File: rtl/rnm_rename_top.sv
module rnm_rename_top
    import rnm_pkg::*;
#(
    parameter int NL   = LANES,
    parameter int NRET = RET_LANES,
    parameter int NREG = ARCH_REGS,
    parameter int NPHY = PHYS_REGS,
    parameter int ARW  = AW,
    parameter int TGW  = TW
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [NL-1:0]            in_lane_vld,
    input  logic [NL-1:0][CLSW-1:0]  in_cls,
    input  logic [NL-1:0][ARW-1:0]   in_src1,
    input  logic [NL-1:0][ARW-1:0]   in_src2,
    input  logic [NL-1:0][ARW-1:0]   in_dst,
    output logic [NL-1:0]            out_vld,
    output logic [NL-1:0]            out_noexec,
    output logic [NL-1:0][TGW-1:0]   out_src1_tag,
    output logic [NL-1:0][TGW-1:0]   out_src2_tag,
    output logic [NL-1:0][TGW-1:0]   out_dst_tag,
    output logic [NL-1:0][TGW-1:0]   out_old_tag,
    input  logic [NRET-1:0]          ret_vld,
    input  logic [NRET-1:0][TGW-1:0] ret_tag
);
    localparam int NRD = 3 * NL;

    logic [NL-1:0]            zero_idiom, need_tag;
    logic [NL-1:0][TGW-1:0]   fresh_tag, new_tag;
    logic [NRD-1:0][ARW-1:0]  rd_idx;
    logic [NRD-1:0][TGW-1:0]  rd_tag;
    logic                     accept, enough;

    genvar g;
    generate
        for (g = 0; g < NL; g++) begin : g_lane
            rnm_zero_detect #(.ARW(ARW)) u_det (
                .cls    (in_cls[g]),
                .src_a  (in_src1[g]),
                .src_b  (in_src2[g]),
                .is_zero(zero_idiom[g])
            );
            assign rd_idx[3*g]     = in_src1[g];
            assign rd_idx[3*g + 1] = in_src2[g];
            assign rd_idx[3*g + 2] = in_dst[g];
            assign need_tag[g]     = in_valid && in_lane_vld[g] && !zero_idiom[g];
            assign new_tag[g]      = zero_idiom[g] ? ZERO_TAG : fresh_tag[g];
        end
    endgenerate

    rnm_free_list #(
        .DEPTH(NPHY), .NPOP(NL), .NPUSH(NRET),
        .FIRST_FREE(NREG + 1), .TGW(TGW)
    ) u_fl (
        .clk     (clk),
        .rst     (rst),
        .pop_req (need_tag),
        .pop_go  (accept),
        .pop_tag (fresh_tag),
        .enough  (enough),
        .push_vld(ret_vld),
        .push_tag(ret_tag)
    );

    rnm_map_table #(
        .NREG(NREG), .NWR(NL), .NRD(NRD), .ARW(ARW), .TGW(TGW)
    ) u_map (
        .clk   (clk),
        .rst   (rst),
        .rd_idx(rd_idx),
        .rd_tag(rd_tag),
        .wr_en (out_vld),
        .wr_idx(in_dst),
        .wr_tag(new_tag)
    );

    assign in_ready = enough;
    assign accept   = in_valid && enough;

    // Intra-group forwarding: later lanes see the youngest earlier writer.
    always_comb begin
        for (int k = 0; k < NL; k++) begin
            logic [TGW-1:0] s1, s2, od;
            s1 = rd_tag[3*k];
            s2 = rd_tag[3*k + 1];
            od = rd_tag[3*k + 2];
            for (int j = 0; j < k; j++) begin
                if (in_lane_vld[j]) begin
                    if (in_dst[j] == in_src1[k]) s1 = new_tag[j];
                    if (in_dst[j] == in_src2[k]) s2 = new_tag[j];
                    if (in_dst[j] == in_dst[k])  od = new_tag[j];
                end
            end
            out_vld[k]      = accept && in_lane_vld[k];
            out_noexec[k]   = out_vld[k] && zero_idiom[k];
            out_src1_tag[k] = zero_idiom[k] ? ZERO_TAG : s1;
            out_src2_tag[k] = zero_idiom[k] ? ZERO_TAG : s2;
            out_dst_tag[k]  = new_tag[k];
            out_old_tag[k]  = od;
        end
    end
endmodule

// File: rtl/rnm_rename_check.sv
module rnm_rename_check
    import rnm_pkg::*;
#(
    parameter int NL  = LANES,
    parameter int ARW = AW,
    parameter int TGW = TW
) (
    input logic                    clk,
    input logic                    rst,
    input logic [NL-1:0]           out_vld,
    input logic [NL-1:0]           out_noexec,
    input logic [NL-1:0][CLSW-1:0] in_cls,
    input logic [NL-1:0][ARW-1:0]  in_src1,
    input logic [NL-1:0][ARW-1:0]  in_src2,
    input logic [NL-1:0][ARW-1:0]  in_dst,
    input logic [NL-1:0][TGW-1:0]  out_src1_tag,
    input logic [NL-1:0][TGW-1:0]  out_dst_tag
);
    genvar k, m;
    generate
        for (k = 0; k < NL; k++) begin : g_ln
            p_idiom_srcs_r3: assert property (@(posedge clk) disable iff (rst)
                (out_vld[k] && out_noexec[k]) |-> (in_src1[k] == in_src2[k]));
            p_idiom_tag_r3: assert property (@(posedge clk) disable iff (rst)
                (out_vld[k] && out_noexec[k]) |-> (out_dst_tag[k] == '0));
            p_andn_runs_r4: assert property (@(posedge clk) disable iff (rst)
                (out_vld[k] && in_cls[k] == CLSW'(CLS_ANDN)) |-> !out_noexec[k]);
            p_alloc_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
                (out_vld[k] && !out_noexec[k]) |-> (out_dst_tag[k] != '0));
            for (m = k + 1; m < NL; m++) begin : g_pair
                p_unique_dst_r9: assert property (@(posedge clk) disable iff (rst)
                    (out_vld[k] && out_vld[m] && !out_noexec[k] && !out_noexec[m])
                    |-> (out_dst_tag[k] != out_dst_tag[m]));
            end
        end
    endgenerate

    // R2: lane 1 reading lane 0's destination gets lane 0's new tag.
    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        (out_vld[0] && out_vld[1] && !out_noexec[1] && in_dst[0] == in_src1[1])
        |-> (out_src1_tag[1] == out_dst_tag[0]));
endmodule

bind rnm_rename_top rnm_rename_check #(.NL(NL), .ARW(ARW), .TGW(TGW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .out_vld     (out_vld),
    .out_noexec  (out_noexec),
    .in_cls      (in_cls),
    .in_src1     (in_src1),
    .in_src2     (in_src2),
    .in_dst      (in_dst),
    .out_src1_tag(out_src1_tag),
    .out_dst_tag (out_dst_tag)
);

// File: tb/rnm_rename_top_test.sv
`timescale 1ns/1ps
module rnm_rename_top_test;
    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready;
    logic [3:0] in_lane_vld;
    logic [3:0][2:0] in_cls;
    logic [3:0][3:0] in_src1, in_src2, in_dst;
    logic [3:0] out_vld, out_noexec;
    logic [3:0][5:0] out_src1_tag, out_src2_tag, out_dst_tag, out_old_tag;
    logic [3:0] ret_vld;
    logic [3:0][5:0] ret_tag;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rnm_rename_top uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        in_valid = 0; in_lane_vld = '0; in_cls = '0;
        in_src1 = '0; in_src2 = '0; in_dst = '0;
        ret_vld = '0; ret_tag = '0;
    endtask

    task automatic lane(input int k, input int c, input int a, input int b, input int d);
        in_lane_vld[k] = 1'b1; in_cls[k] = 3'(c);
        in_src1[k] = 4'(a); in_src2[k] = 4'(b); in_dst[k] = 4'(d);
    endtask

    task automatic lane_chk(input string req, input int k, input int s1, input int s2,
                            input int d, input int od, input int nx);
        chk({req, " src1"}, out_src1_tag[k], s1);
        chk({req, " src2"}, out_src2_tag[k], s2);
        chk({req, " dst"},  out_dst_tag[k], d);
        chk({req, " old"},  out_old_tag[k], od);
        chk({req, " noexec"}, out_noexec[k], nx);
    endtask

    // Inputs change at negedge, checks at negedge+1, commit at next posedge.
    task automatic begin_group();
        @(negedge clk); idle(); in_valid = 1;
    endtask

    task automatic end_group();
        @(posedge clk); #0.1; idle();
    endtask

    task automatic t_reset_and_alloc();  // R1 R4 R2
        begin_group();
        lane(0, 0, 1, 2, 3);
        lane(1, 6, 3, 3, 4);
        lane(2, 0, 5, 6, 7);
        lane(3, 0, 7, 4, 3);
        #1;
        chk("R7 ready", in_ready, 1);
        chk("R1 vld", out_vld, 4'hf);
        lane_chk("R1 l0", 0, 2, 3, 17, 4, 0);
        lane_chk("R4 l1", 1, 17, 17, 18, 5, 0);
        lane_chk("R1 l2", 2, 6, 7, 19, 8, 0);
        lane_chk("R2 l3", 3, 19, 18, 20, 17, 0);
        end_group();
    endtask

    task automatic t_same_dest();  // R2
        begin_group();
        for (int k = 0; k < 4; k++) lane(k, 0, 9, 0, 9);
        #1;
        lane_chk("R2 w0", 0, 10, 1, 21, 10, 0);
        lane_chk("R2 w1", 1, 21, 1, 22, 21, 0);
        lane_chk("R2 w2", 2, 22, 1, 23, 22, 0);
        lane_chk("R2 w3", 3, 23, 1, 24, 23, 0);
        end_group();
        begin_group();
        lane(0, 0, 9, 3, 10);
        #1;
        lane_chk("R2 youngest", 0, 24, 20, 25, 11, 0);
        end_group();
    endtask

    task automatic t_idioms();  // R3 R5
        begin_group();
        lane(0, 1, 3, 3, 3);
        lane(1, 2, 4, 4, 4);
        lane(2, 5, 11, 11, 12);
        lane(3, 3, 1, 1, 1);
        #1;
        chk("R3 vld", out_vld, 4'hf);
        lane_chk("R3 xor", 0, 0, 0, 0, 20, 1);
        lane_chk("R3 sub", 1, 0, 0, 0, 18, 1);
        lane_chk("R3 cmpgt", 2, 0, 0, 0, 13, 1);
        lane_chk("R5 fxor", 3, 0, 0, 0, 2, 1);
        end_group();
        begin_group();
        lane(0, 0, 3, 12, 2);
        #1;
        lane_chk("R5 no tag used", 0, 0, 0, 26, 3, 0);
        end_group();
    endtask

    task automatic t_mixed();  // R2 R3 R4
        begin_group();
        lane(0, 4, 5, 5, 6);
        lane(1, 0, 6, 5, 8);
        lane(3, 7, 6, 6, 6);
        #1;
        chk("R7 partial vld", out_vld, 4'b1011);
        lane_chk("R3 vsub", 0, 0, 0, 0, 7, 1);
        lane_chk("R2 after idiom", 1, 0, 6, 27, 9, 0);
        lane_chk("R4 misc", 3, 0, 0, 28, 0, 0);
        end_group();
    endtask

    task automatic t_exhaust();  // R6 R7 R8
        for (int g = 0; g < 8; g++) begin
            begin_group();
            for (int k = 0; k < 4; k++) lane(k, 0, 0, 0, 15);
            #1;
            chk("R9 filler", out_dst_tag[0], 29 + 4*g);
            end_group();
        end
        begin_group();
        for (int k = 0; k < 4; k++) lane(k, 0, 0, 0, 14);
        #1;
        chk("R7 stall ready", in_ready, 0);
        chk("R7 stall vld", out_vld, 0);
        end_group();
        begin_group();
        for (int k = 0; k < 4; k++) lane(k, 1, 14, 14, 14);
        #1;
        chk("R6 ready", in_ready, 1);
        chk("R6 noexec", out_noexec, 4'hf);
        end_group();
        @(negedge clk); idle();
        ret_vld = 4'b0111; ret_tag[0] = 6'd10; ret_tag[1] = 6'd0; ret_tag[2] = 6'd11;
        @(posedge clk); #0.1; idle();
        begin_group();
        for (int k = 0; k < 4; k++) lane(k, 0, 0, 0, 13);
        #1;
        chk("R7 ready after retire", in_ready, 1);
        chk("R8 d0", out_dst_tag[0], 61);
        chk("R8 d1", out_dst_tag[1], 62);
        chk("R8 d2", out_dst_tag[2], 63);
        chk("R8 d3", out_dst_tag[3], 10);
        chk("R8 old", out_old_tag[0], 14);
        end_group();
        begin_group();
        lane(0, 0, 0, 0, 12); lane(1, 0, 0, 0, 12);
        #1;
        chk("R8 zero not freed", in_ready, 0);
        end_group();
        begin_group();
        lane(0, 0, 0, 0, 12);
        #1;
        chk("R8 last tag", out_dst_tag[0], 11);
        chk("R8 last vld", out_vld, 4'b0001);
        end_group();
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #0.1 rst = 0;
        t_reset_and_alloc();
        t_same_dest();
        t_idioms();
        t_mixed();
        t_exhaust();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule